// File: doc/BRIEF.md
# NTT Coefficient Rejection Sampler

This block turns a stream of uniform random bytes into the 256 coefficients of one polynomial modulo 3329, in the form that a number-theoretic-transform stage expects. Each accepted input beat carries six bytes, which form two byte groups of three. Each group yields two 12-bit candidates. A candidate is kept only when it is a valid residue, which means it is below the modulus. Kept values leave the block in their input order, four to an output beat.

The candidates and their compare results are registered in one stage. A second stage packs the kept values into output beats. Because a variable number of values survive in each cycle, up to three leftovers wait in a staging register and join the next beat. A two-entry output queue absorbs downstream stalls.

After the 64th output beat, which carries the 256th coefficient, the block marks that beat as last and discards any surplus values. It then refuses input until `start` is pulsed. A `start` pulse abandons any work in progress and begins a fresh polynomial.

Top module: `ntt_reject_sampler`

## Requirements
- R1: Input bytes are numbered from the least significant end. Byte group g uses bytes b0 = in_data[24g+7:24g], b1 = in_data[24g+15:24g+8] and b2 = in_data[24g+23:24g+16]. Its first candidate is b0 + 256·(b1 mod 16) and its second candidate is floor(b1/16) + 16·b2.
- R2: A candidate is kept when it is strictly below 3329 and dropped otherwise. Under this rule 3328 is kept, while 3329 and 4095 are dropped.
- R3: Kept values come out in input order. Within an input beat the order is group 0 first candidate, group 0 second candidate, group 1 first candidate, group 1 second candidate. Earlier input beats come before later ones.
- R4: An output beat holds four coefficients. Lane k sits in out_data[12k+11:12k], so lane 0 is in bits [11:0].
- R5: Kept values that do not fill a complete beat are held back. They are merged with the values of later input beats, and none is lost or duplicated.
- R6: A polynomial consists of exactly 64 output beats. out_last is 1 on the 64th beat and 0 on every other beat. Kept values beyond the 256th are discarded.
- R7: After the 64th beat has been formed, in_ready stays 0 and no further output beat appears until `start` is pulsed.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data stays unchanged. No beat is lost or repeated under back-pressure.
- R9: After reset, out_valid is 0 and in_ready is 1. The block then collects a new polynomial without needing a `start` pulse.
- R10: A `start` pulse discards the staged values, the registered candidates and the queued output beats. In the next cycle out_valid is 0 and in_ready is 1, and the coefficient count begins again at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a new polynomial |
| in_valid | input | 1 | Input beat is present |
| in_ready | output | 1 | Block accepts the input beat this cycle |
| in_data | input | 48 | Six random bytes (two byte groups) |
| out_valid | output | 1 | Output beat is present |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | 48 | Four packed 12-bit coefficients |
| out_last | output | 1 | Marks the beat that carries coefficient 256 |

## Verification
The hardest situation to reach from the ports is the end of a polynomial. There, the staging register already holds leftovers and the final input beat carries more kept values than the last output beat can take. This has to coincide with a full output queue, so the ready path back to the input matters at the same moment. To reach it, the stimulus runs whole polynomials under several downstream ready rates, including long stall runs, and uses byte mixes whose acceptance rates range from near zero to full. Directed byte groups place candidates exactly at 3328 and 3329. A restart in the middle of a polynomial, issued while the output queue is full, checks that nothing stale survives.

// File: rtl/rs_pkg.sv
// Shared constants for the rejection sampler.
// Assumes: candidates are 12 bits wide and byte groups are three bytes.
package rs_pkg;
    localparam int CW      = 12;  // coefficient / candidate width
    localparam int BYTE_W  = 8;
    localparam int GROUP_W = 3 * BYTE_W;
endpackage

// File: rtl/rs_extract.sv
// Candidate extraction and compare stage.
// Splits each three-byte group into two 12-bit candidates, compares each
// candidate against the modulus, and registers values and keep flags together.
// Assumes: the consumer asserts take for exactly one cycle per registered beat.
module rs_extract
    import rs_pkg::*;
#(
    parameter int TRIPLES = 2,
    parameter int Q       = 3329,
    localparam int CANDS  = 2 * TRIPLES,
    localparam int IN_W   = GROUP_W * TRIPLES
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic                        load,
    input  logic [IN_W-1:0]             in_bytes,
    input  logic                        take,
    output logic                        vld_q,
    output logic [CANDS-1:0][CW-1:0]    cand_q,
    output logic [CANDS-1:0]            keep_q
);
    logic [CANDS-1:0][CW-1:0] cand_w;
    logic [CANDS-1:0]         keep_w;

    // one extractor and two comparators per byte group
    for (genvar t = 0; t < TRIPLES; t++) begin : g_group
        logic [BYTE_W-1:0] b0, b1, b2;
        assign b0 = in_bytes[GROUP_W*t +: BYTE_W];
        assign b1 = in_bytes[GROUP_W*t + BYTE_W +: BYTE_W];
        assign b2 = in_bytes[GROUP_W*t + 2*BYTE_W +: BYTE_W];
        assign cand_w[2*t]   = {b1[3:0], b0};
        assign cand_w[2*t+1] = {b2, b1[7:4]};
        assign keep_w[2*t]   = cand_w[2*t]   < CW'(Q);
        assign keep_w[2*t+1] = cand_w[2*t+1] < CW'(Q);
    end

    // pipeline register: candidates and compare results move together
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            vld_q  <= 1'b0;
            cand_q <= '0;
            keep_q <= '0;
        end else if (load) begin
            vld_q  <= 1'b1;
            cand_q <= cand_w;
            keep_q <= keep_w;
        end else if (take) begin
            vld_q  <= 1'b0;
        end
    end

    // a registered beat that is not consumed must survive to the next cycle
    assert_stage_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && !take && !flush && !load) |=> (vld_q && $stable(cand_q) && $stable(keep_q)));
endmodule

// File: rtl/rs_compact.sv
// Compaction and packing stage.
// Merges leftover staged values with this cycle's kept candidates, preserving
// order, and emits one full beat whenever four or more values are available.
// It counts the beats and flags the final one. Staged values are discarded
// when the final beat is formed.
// Assumes: the lane count equals the candidate count per input beat, so at
// most one beat forms per cycle; in_vld is only raised when the queue has room.
module rs_compact
    import rs_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int N_COEF = 256,
    localparam int MERGE = 2 * LANES - 1,
    localparam int SW    = $clog2(MERGE + 1),
    localparam int BEATS = N_COEF / LANES,
    localparam int BW    = $clog2(BEATS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic                        in_vld,
    input  logic [LANES-1:0][CW-1:0]    cand,
    input  logic [LANES-1:0]            keep,
    output logic                        beat_push,
    output logic [LANES*CW-1:0]         beat_data,
    output logic                        beat_last,
    output logic                        poly_done
);
    logic [CW-1:0]  stage_q   [LANES-1];
    logic [SW-1:0]  stage_cnt_q;
    logic [BW-1:0]  beat_cnt_q;
    logic [CW-1:0]  merged    [MERGE];
    logic [SW-1:0]  total;
    logic [LANES-1:0] keep_eff;

    assign keep_eff = in_vld ? keep : '0;

    // order-preserving merge: staged values first, then kept candidates
    always_comb begin
        for (int m = 0; m < MERGE; m++) merged[m] = '0;
        for (int i = 0; i < LANES - 1; i++) begin
            if (SW'(i) < stage_cnt_q) merged[i] = stage_q[i];
        end
        total = stage_cnt_q;
        for (int j = 0; j < LANES; j++) begin
            if (keep_eff[j]) begin
                merged[total] = cand[j];
                total = total + SW'(1);
            end
        end
    end

    // beat formation: the first four merged values go out in lane order
    always_comb begin
        for (int k = 0; k < LANES; k++) beat_data[k*CW +: CW] = merged[k];
    end

    assign beat_push = in_vld && (total >= SW'(LANES));
    assign beat_last = (beat_cnt_q == BW'(BEATS - 1));
    assign poly_done = beat_push && beat_last;

    // staging and beat count update
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            stage_cnt_q <= '0;
            beat_cnt_q  <= '0;
            for (int i = 0; i < LANES - 1; i++) stage_q[i] <= '0;
        end else if (poly_done) begin
            stage_cnt_q <= '0;
            beat_cnt_q  <= beat_cnt_q + BW'(1);
            for (int i = 0; i < LANES - 1; i++) stage_q[i] <= '0;
        end else if (beat_push) begin
            stage_cnt_q <= total - SW'(LANES);
            beat_cnt_q  <= beat_cnt_q + BW'(1);
            for (int i = 0; i < LANES - 1; i++) stage_q[i] <= merged[i + LANES];
        end else begin
            stage_cnt_q <= total;
            for (int i = 0; i < LANES - 1; i++) stage_q[i] <= merged[i];
        end
    end

    // leftovers never reach a full beat
    assert_stage_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stage_cnt_q < SW'(LANES));
    // no beat beyond the polynomial length
    assert_beat_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        beat_push |-> (beat_cnt_q < BW'(BEATS)));
endmodule

// File: rtl/rs_skid.sv
// Two-entry output queue.
// Decouples the downstream ready from the internal pipeline and holds each
// beat until it is taken.
// Assumes: push is only raised when full is low.
module rs_skid #(
    parameter int W = 49
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] dout
);
    logic [W-1:0] mem_q [2];
    logic         head_q;
    logic [1:0]   cnt_q;
    logic         pop;
    logic         wr_idx;

    assign out_valid = (cnt_q != 2'd0);
    assign full      = (cnt_q == 2'd2);
    assign pop       = out_valid && out_ready;
    assign wr_idx    = head_q ^ (cnt_q != 2'd0);
    assign dout      = mem_q[head_q];

    // entry storage, written at the tail
    always_ff @(posedge clk) begin
        if (push) mem_q[wr_idx] <= din;
    end

    // occupancy and head pointer
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q  <= 2'd0;
            head_q <= 1'b0;
        end else begin
            if (pop) head_q <= ~head_q;
            cnt_q <= cnt_q + {1'b0, push} - {1'b0, pop};
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n || clear)
        (out_valid && !out_ready) |=> (out_valid && $stable(dout)));
endmodule

// File: rtl/ntt_reject_sampler.sv
// Rejection sampler top.
// Accepts two byte groups per input beat and keeps the candidates below Q.
// Emits the kept values four to a beat and stops after N_COEF coefficients
// until start is pulsed.
// Assumes: start is a single-cycle pulse; in_data is only sampled with in_ready.
module ntt_reject_sampler
    import rs_pkg::*;
#(
    parameter int TRIPLES  = 2,
    parameter int N_COEF   = 256,
    parameter int Q        = 3329,
    localparam int LANES   = 2 * TRIPLES,
    localparam int IN_W    = GROUP_W * TRIPLES,
    localparam int OUT_W   = LANES * CW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_data,
    output logic             out_last
);
    logic                       running_q;
    logic                       s1_vld;
    logic [LANES-1:0][CW-1:0]   s1_cand;
    logic [LANES-1:0]           s1_keep;
    logic                       skid_full;
    logic                       take;
    logic                       load;
    logic                       beat_push;
    logic [OUT_W-1:0]           beat_data;
    logic                       beat_last;
    logic                       poly_done;
    logic [OUT_W:0]             skid_dout;

    assign take     = s1_vld && running_q && !skid_full && !start;
    assign in_ready = running_q && !start && (!s1_vld || take);
    assign load     = in_valid && in_ready;

    // collection enable: set by reset or start, cleared by the final beat
    always_ff @(posedge clk) begin
        if (!rst_n)         running_q <= 1'b1;
        else if (start)     running_q <= 1'b1;
        else if (poly_done) running_q <= 1'b0;
    end

    rs_extract #(.TRIPLES(TRIPLES), .Q(Q)) i_extract (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (start || poly_done),
        .load     (load),
        .in_bytes (in_data),
        .take     (take),
        .vld_q    (s1_vld),
        .cand_q   (s1_cand),
        .keep_q   (s1_keep)
    );

    rs_compact #(.LANES(LANES), .N_COEF(N_COEF)) i_compact (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (start),
        .in_vld    (take),
        .cand      (s1_cand),
        .keep      (s1_keep),
        .beat_push (beat_push),
        .beat_data (beat_data),
        .beat_last (beat_last),
        .poly_done (poly_done)
    );

    rs_skid #(.W(OUT_W + 1)) i_skid (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .push      (beat_push),
        .din       ({beat_last, beat_data}),
        .full      (skid_full),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .dout      (skid_dout)
    );

    assign out_data = skid_dout[OUT_W-1:0];
    assign out_last = skid_dout[OUT_W];

    // once the final beat forms, input must close on the next cycle
    assert_input_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (poly_done && !start) |=> !in_ready);
    // a start pulse leaves an empty output side behind
    assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!out_valid && in_ready));
endmodule

// File: tb/test_ntt_reject_sampler.sv
`timescale 1ns/1ps
module test_ntt_reject_sampler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [47:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [47:0] out_data;
    logic        out_last;

    int total_checks = 0;
    int bad_checks   = 0;
    int exp_q[$];
    int got   = 0;
    int beats = 0;
    bit hold_pend = 0;
    logic [47:0] hold_data;

    always #2.5 clk = ~clk;

    ntt_reject_sampler i_ntt_reject_sampler (
        .clk(clk), .rst_n(rst_n), .start(start),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total_checks++;
        if (!ok) begin
            bad_checks++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // candidate k of an input beat, following R1
    function automatic int cand_of(input logic [47:0] d, input int k);
        logic [7:0] b0, b1, b2;
        b0 = d[24*(k/2) +: 8];
        b1 = d[24*(k/2) + 8 +: 8];
        b2 = d[24*(k/2) + 16 +: 8];
        if (k % 2 == 0) return int'(b0) + 256 * int'(b1 & 8'h0F);
        else            return int'(b1 >> 4) + 16 * int'(b2);
    endfunction

    function automatic logic [23:0] pick_group(input int mode);
        int sel;
        if (mode == 0) return 24'($urandom);
        sel = int'($urandom % 6);
        if (mode == 2 && sel < 4) return 24'hFFFFFF;        // all rejected (R2)
        case (sel)
            0: return 24'hD01D01;   // candidates 3329, 3329 -> dropped (R2)
            1: return 24'hD00D00;   // candidates 3328, 3328 -> kept (R2)
            2: return 24'hFFFFFF;   // 4095, 4095 -> dropped
            3: return 24'h000000;   // 0, 0 -> kept
            default: return 24'($urandom);
        endcase
    endfunction

    // one clock cycle: drive at the falling edge, observe settled outputs
    task automatic step(input bit v, input logic [47:0] d, input bit r);
        logic [47:0] exp_beat;
        @(negedge clk);
        in_valid = v; in_data = d; out_ready = r;
        #1;
        if (hold_pend)
            check(out_valid && out_data == hold_data, "R8 hold under stall", {15'd0, out_valid, out_data}, {16'h1, hold_data});
        hold_pend = out_valid && !out_ready;
        hold_data = out_data;
        if (in_valid && in_ready)
            for (int k = 0; k < 4; k++) begin
                int c = cand_of(in_data, k);
                if (c < 3329) exp_q.push_back(c);
            end
        if (out_valid && out_ready) begin
            if (beats >= 64) begin
                check(1'b0, "R6 beat after last", 64'(beats), 64'd63);
            end else begin
                for (int k = 0; k < 4; k++)
                    exp_beat[12*k +: 12] = (got + k < exp_q.size()) ? 12'(exp_q[got + k]) : 12'hFFF;
                check(out_data == exp_beat, "R1/R2/R3/R4/R5 beat data", 64'(out_data), 64'(exp_beat));
                check(out_last == (beats == 63), "R6 last flag", 64'(out_last), 64'(beats == 63));
            end
            got += 4;
            beats++;
        end
    endtask

    task automatic run_poly(input int mode, input int ready_pct, input int stop_at);
        int guard = 0;
        while (beats < stop_at && guard < 20000) begin
            logic [47:0] d = {pick_group(mode), pick_group(mode)};
            bit v = ($urandom % 100) < 75;
            bit r = ($urandom % 100) < ready_pct;
            if (ready_pct < 50 && (guard % 40) < 12) r = 1'b0;  // stall bursts
            step(v, d, r);
            guard++;
        end
        check(beats >= stop_at, "R6 beat count reached", 64'(beats), 64'(stop_at));
    endtask

    // after the final beat: input closed, nothing more emitted (R7)
    task automatic idle_check();
        bit ok = 1'b1;
        for (int i = 0; i < 20; i++) begin
            step(1'b1, {16'h0000, 32'($urandom)}, 1'b1);
            if (out_valid || in_ready) ok = 1'b0;
        end
        check(ok, "R7 closed after last", {62'd0, out_valid, in_ready}, 64'd0);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        exp_q.delete(); got = 0; beats = 0; hold_pend = 0;
        #1;
        check(!out_valid && in_ready, "R10 state after start", {62'd0, out_valid, in_ready}, 64'd1);
    endtask

    initial begin
        #(200000 * 5);
        check(1'b0, "watchdog", 64'(beats), 64'd64);
        $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7562));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!out_valid && in_ready, "R9 reset state", {62'd0, out_valid, in_ready}, 64'd1);

        // R9: first polynomial straight after reset, random bytes, light stalls
        run_poly(0, 90, 64);
        idle_check();

        // R2/R3: directed boundary groups, half-rate ready
        pulse_start();
        run_poly(1, 50, 64);
        idle_check();

        // R5: mostly rejected groups, so leftovers are carried across many beats
        pulse_start();
        run_poly(2, 100, 64);
        idle_check();

        // R10: restart mid-polynomial with the output queue filled
        pulse_start();
        run_poly(0, 60, 10);
        for (int i = 0; i < 8; i++) step(1'b1, 48'($urandom) ^ (48'($urandom) << 32), 1'b0);
        check(out_valid, "R8 queue holds beats under stall", 64'(out_valid), 64'd1);
        pulse_start();
        run_poly(0, 30, 64);
        idle_check();

        $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
        $finish;
    end
endmodule